// File: doc/BRIEF.md
# Asynchronous DRAM Device Cycle Model

This block stands in for one asynchronous page-mode DRAM device in self-checking tests of a memory controller. It oversamples the four active-low strobes (row strobe, column strobe, write enable, output enable) on a fast clock and detects their edges. From the order of those edges it decides what kind of cycle is under way: a read, an early write, a late write, a read-modify-write, a refresh that uses an internal row counter (column strobe before row strobe), or a refresh of the row on the address bus (row strobe alone). It then reads or writes a small internal array and says whether the data bus is driven.

The row is latched on the row-strobe fall and the column on each column-strobe fall. Several columns can be accessed under one row strobe. A parameter selects the output hold behaviour. In fast-page mode the output floats when the column strobe rises. In extended-data-out mode the read data stays on the bus until the row strobe rises. Every refresh is reported as a one-cycle pulse together with the row it covered. A one-cycle error pulse flags orderings that a controller must not produce. Analog timing is not modelled; only the order of edges matters.

Top module: `dram_cycle_model`

## Requirements
- R1: After reset, dq_oe_o, rfsh_o and err_o are 0, and the first counter-based refresh reports row 0.
- R2: Early write. If we_ni is already low at the clock edge that samples a cas_ni fall inside a row cycle, dq_i is stored at {row, column}. dq_oe_o stays 0 during that access, even with oe_ni low.
- R3: Read. A cas_ni fall with we_ni high loads the addressed word, and it appears on dq_o one cycle later. dq_oe_o is 1 only while oe_ni is low.
- R4: Late write. If we_ni falls after cas_ni while oe_ni is high, the value of dq_i sampled at the we_ni fall is stored. The value present at the cas_ni fall is not stored.
- R5: A late write tried while oe_ni is low stores nothing. The bus keeps driving the old word at that location.
- R6: Read-modify-write. Inside one column access, the old word is read with oe_ni low. After oe_ni goes high, a we_ni fall replaces the word.
- R7: With EDO=0, dq_oe_o returns to 0 in the cycle after the cas_ni rise is sampled.
- R8: With EDO=1, the read word stays driven after cas_ni rises and until the row strobe rises. dq_oe_o is 0 in the cycle after the ras_ni rise is sampled.
- R9: A cas_ni fall followed by a ras_ni fall is a counter refresh. rfsh_o pulses for one cycle with rfsh_row_o equal to the counter. The counter then advances and wraps from REFRESH_ROWS-1 to 0.
- R10: A ras_ni fall with cas_ni high pulses rfsh_o for one cycle with rfsh_row_o equal to addr_i at that fall. The refresh counter is not changed.
- R11: A cas_ni fall outside a row cycle with we_ni low pulses err_o for one cycle. A we_ni fall with no cycle active raises no error.
- R12: Any we_ni edge while a counter refresh is armed or running pulses err_o for one cycle and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| dq_i | input | DATA_W | Write data from the controller |
| dq_o | output | DATA_W | Read data |
| dq_oe_o | output | 1 | 1 when the device drives the data bus |
| rfsh_o | output | 1 | One-cycle pulse per refresh |
| rfsh_row_o | output | ADDR_W | Row covered by the last refresh |
| err_o | output | 1 | One-cycle pulse on an illegal strobe order |

## Verification
Every location is written with early writes in page mode and read back in page mode. Each column-strobe rise during read-back shows the difference between the fast-page and EDO instances. Single locations then go through a late write with OE high, a late write with OE low, and a read-modify-write. These show that the captured data is taken at the later edge and that a write is suppressed when OE is low. A run of counter refreshes goes past the wrap point, with a row-strobe-only refresh placed in the middle to confirm it leaves the counter alone. Bad orderings that do and do not raise the error pulse finish the run.

// File: rtl/dram_model_pkg.sv
package dram_model_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CBR_ARM = 2'd1,
    ST_ROW     = 2'd2,
    ST_CBR     = 2'd3
  } cyc_st_e;
endpackage

// File: rtl/dram_strobe_edges.sv
module dram_strobe_edges #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  // strobes idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '1;
    else         lvl_q <= lvl_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign fall_o[g] = lvl_q[g] & ~lvl_i[g];
    assign rise_o[g] = ~lvl_q[g] & lvl_i[g];
  end
endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
  parameter int ADDR_W       = 3,
  parameter int REFRESH_ROWS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] row_o
);
  localparam logic [ADDR_W-1:0] LastRow = ADDR_W'(REFRESH_ROWS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_o <= '0;
    else if (inc_i)  row_o <= (row_o == LastRow) ? '0 : row_o + 1'b1;
  end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
  parameter int WORD_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int Depth = 1 << WORD_W;

  logic [DATA_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
  import dram_model_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter bit EDO    = 1'b0,
  localparam int WORD_W = 2 * ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ras_fall_i,
  input  logic              ras_rise_i,
  input  logic              cas_fall_i,
  input  logic              cas_rise_i,
  input  logic              we_fall_i,
  input  logic              we_rise_i,
  input  logic [ADDR_W-1:0] ctr_row_i,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_waddr_o,
  output logic [WORD_W-1:0] mem_raddr_o,
  output logic              rd_load_o,
  output logic              drive_o,
  output logic              cbr_inc_o,
  output logic              rfsh_o,
  output logic [ADDR_W-1:0] rfsh_row_o,
  output logic              err_o
);
  cyc_st_e           st_q, st_d;
  logic [ADDR_W-1:0] row_q, row_d, col_q, col_d, rrow_d;
  logic              drive_d, wr_done_q, wr_done_d, rfsh_d, err_d;

  assign mem_raddr_o = {row_q, addr_i};

  always_comb begin
    st_d        = st_q;
    row_d       = row_q;
    col_d       = col_q;
    drive_d     = drive_o;
    wr_done_d   = wr_done_q;
    mem_we_o    = 1'b0;
    mem_waddr_o = {row_q, col_q};
    rd_load_o   = 1'b0;
    cbr_inc_o   = 1'b0;
    rfsh_d      = 1'b0;
    rrow_d      = rfsh_row_o;
    err_d       = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ras_fall_i) begin
          row_d  = addr_i;
          st_d   = ST_ROW;
          rfsh_d = 1'b1;
          rrow_d = addr_i;
        end else if (cas_fall_i) begin
          st_d  = ST_CBR_ARM;
          err_d = ~we_ni;
        end
      end
      ST_CBR_ARM: begin
        err_d = we_fall_i | we_rise_i;
        if (ras_fall_i) begin
          st_d      = ST_CBR;
          cbr_inc_o = 1'b1;
          rfsh_d    = 1'b1;
          rrow_d    = ctr_row_i;
        end else if (cas_rise_i) begin
          st_d = ST_IDLE;
        end
      end
      ST_CBR: begin
        err_d = we_fall_i | we_rise_i;
        // CAS still low at RAS rise re-arms a hidden refresh
        if (ras_rise_i) st_d = cas_ni ? ST_IDLE : ST_CBR_ARM;
      end
      ST_ROW: begin
        if (ras_rise_i) begin
          st_d    = cas_ni ? ST_IDLE : ST_CBR_ARM;
          drive_d = 1'b0;
        end else begin
          if (cas_fall_i) begin
            col_d = addr_i;
            if (!we_ni) begin
              mem_we_o    = 1'b1;
              mem_waddr_o = {row_q, addr_i};
              drive_d     = 1'b0;
              wr_done_d   = 1'b1;
            end else begin
              rd_load_o = 1'b1;
              drive_d   = 1'b1;
              wr_done_d = 1'b0;
            end
          end else if (we_fall_i && !cas_ni && !wr_done_q && oe_ni) begin
            // late write; with OE low it is dropped and the read stays live
            mem_we_o  = 1'b1;
            drive_d   = 1'b0;
            wr_done_d = 1'b1;
          end
          if (cas_rise_i && !EDO) drive_d = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      drive_o    <= 1'b0;
      wr_done_q  <= 1'b0;
      rfsh_o     <= 1'b0;
      rfsh_row_o <= '0;
      err_o      <= 1'b0;
    end else begin
      st_q       <= st_d;
      row_q      <= row_d;
      col_q      <= col_d;
      drive_o    <= drive_d;
      wr_done_q  <= wr_done_d;
      rfsh_o     <= rfsh_d;
      rfsh_row_o <= rrow_d;
      err_o      <= err_d;
    end
  end
endmodule

// File: rtl/dram_cycle_model.sv
module dram_cycle_model
  import dram_model_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 8,
  parameter int REFRESH_ROWS = 6,
  parameter bit EDO          = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              rfsh_o,
  output logic [ADDR_W-1:0] rfsh_row_o,
  output logic              err_o
);
  localparam int WORD_W = 2 * ADDR_W;

  logic [2:0]        fall, rise;
  logic [ADDR_W-1:0] ctr_row;
  logic              cbr_inc, mem_we, rd_load, drive;
  logic [WORD_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata, rd_q;

  dram_strobe_edges #(.N(3)) u_edges (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({we_ni, cas_ni, ras_ni}),
    .fall_o (fall),
    .rise_o (rise)
  );

  dram_refresh_ctr #(.ADDR_W(ADDR_W), .REFRESH_ROWS(REFRESH_ROWS)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (cbr_inc),
    .row_o  (ctr_row)
  );

  dram_cycle_fsm #(.ADDR_W(ADDR_W), .EDO(EDO)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cas_ni      (cas_ni),
    .we_ni       (we_ni),
    .oe_ni       (oe_ni),
    .addr_i      (addr_i),
    .ras_fall_i  (fall[0]),
    .ras_rise_i  (rise[0]),
    .cas_fall_i  (fall[1]),
    .cas_rise_i  (rise[1]),
    .we_fall_i   (fall[2]),
    .we_rise_i   (rise[2]),
    .ctr_row_i   (ctr_row),
    .mem_we_o    (mem_we),
    .mem_waddr_o (waddr),
    .mem_raddr_o (raddr),
    .rd_load_o   (rd_load),
    .drive_o     (drive),
    .cbr_inc_o   (cbr_inc),
    .rfsh_o      (rfsh_o),
    .rfsh_row_o  (rfsh_row_o),
    .err_o       (err_o)
  );

  dram_cell_array #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (waddr),
    .wdata_i (dq_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_load) rd_q <= rdata;
  end

  assign dq_o    = rd_q;
  assign dq_oe_o = drive & ~oe_ni;
endmodule

// File: rtl/dram_cycle_chk.sv
module dram_cycle_chk #(
  parameter bit EDO = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_ni,
  input logic cas_ni,
  input logic we_ni,
  input logic oe_ni,
  input logic dq_oe_o,
  input logic rfsh_o
);
  // R3
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !oe_ni);

  // R2
  early_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_ni) && !we_ni && !ras_ni && !$fell(ras_ni)) |=> !dq_oe_o);

  // R8
  ras_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !$past(ras_ni));

  // R10
  rfsh_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_o |-> (!$past(ras_ni) && $past(ras_ni, 2)));

  if (!EDO) begin : g_fpm
    // R7
    fpm_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dq_oe_o |-> !$past(cas_ni));
  end
endmodule

bind dram_cycle_model dram_cycle_chk #(.EDO(EDO)) u_chk (.*);

// File: tb/sim_dram_cycle_model.sv
module sim_dram_cycle_model;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int SPAN = 6;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ras = 1'b1, cas = 1'b1, we = 1'b1, oe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq = '0;
  logic [DW-1:0] q0, q1;
  logic oe0, oe1, rf0, rf1, er0, er1;
  logic [AW-1:0] rr0, rr1;

  int checks = 0;
  int failures = 0;
  int ncbr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cycle_model #(.ADDR_W(AW), .DATA_W(DW), .REFRESH_ROWS(SPAN), .EDO(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ras_ni(ras), .cas_ni(cas), .we_ni(we), .oe_ni(oe),
    .addr_i(addr), .dq_i(dq), .dq_o(q0), .dq_oe_o(oe0), .rfsh_o(rf0),
    .rfsh_row_o(rr0), .err_o(er0));

  dram_cycle_model #(.ADDR_W(AW), .DATA_W(DW), .REFRESH_ROWS(SPAN), .EDO(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .ras_ni(ras), .cas_ni(cas), .we_ni(we), .oe_ni(oe),
    .addr_i(addr), .dq_i(dq), .dq_o(q1), .dq_oe_o(oe1), .rfsh_o(rf1),
    .rfsh_row_o(rr1), .err_o(er1));

  function automatic logic [DW-1:0] pat(int r, int c);
    return DW'((r * 8 + c) * 29 + 7);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(int r, int c, logic [DW-1:0] exp, string tag);
    addr = AW'(r); ras = 1'b0; step();
    addr = AW'(c); cas = 1'b0; step();
    chk({tag, " drive"}, 32'(oe0), 1);
    chk({tag, " data"}, 32'(q0), 32'(exp));
    cas = 1'b1; step();
    ras = 1'b1; step();
  endtask

  task automatic cbr();
    cas = 1'b0; step();
    ras = 1'b0; step();
    chk("R9 cbr pulse", 32'(rf0), 1);
    chk("R9 cbr row u0", 32'(rr0), 32'(ncbr % SPAN));
    chk("R9 cbr row u1", 32'(rr1), 32'(ncbr % SPAN));
    ncbr++;
    cas = 1'b1; step();
    chk("R9 pulse one cycle", 32'(rf0), 0);
    ras = 1'b1; step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk("R1 dq_oe u0", 32'(oe0), 0);
    chk("R1 dq_oe u1", 32'(oe1), 0);
    chk("R1 err", 32'(er0), 0);
    chk("R1 rfsh", 32'(rf0), 0);

    // R2 early-write sweep in page mode, OE held low
    for (int r = 0; r < 8; r++) begin
      addr = AW'(r); ras = 1'b0; step();
      chk("R10 ras cycle row", 32'(rr0), 32'(r));
      we = 1'b0; step();
      for (int c = 0; c < 8; c++) begin
        addr = AW'(c); dq = pat(r, c); cas = 1'b0; step();
        chk("R2 early write hiZ u0", 32'(oe0), 0);
        chk("R2 early write hiZ u1", 32'(oe1), 0);
        cas = 1'b1; step();
      end
      we = 1'b1; ras = 1'b1; step();
    end

    // R3 page-mode read sweep, R7/R8 output hold after CAS rise
    for (int r = 0; r < 8; r++) begin
      addr = AW'(r); ras = 1'b0; step();
      for (int c = 0; c < 8; c++) begin
        addr = AW'(c); cas = 1'b0; step();
        chk("R3 read drive u0", 32'(oe0), 1);
        chk("R2 R3 read data u0", 32'(q0), 32'(pat(r, c)));
        chk("R3 read drive u1", 32'(oe1), 1);
        chk("R3 read data u1", 32'(q1), 32'(pat(r, c)));
        cas = 1'b1; step();
        chk("R7 fpm float", 32'(oe0), 0);
        chk("R8 edo hold drive", 32'(oe1), 1);
        chk("R8 edo hold data", 32'(q1), 32'(pat(r, c)));
      end
      ras = 1'b1; step();
      chk("R8 edo release", 32'(oe1), 0);
    end

    // R3 OE gating
    addr = 3'd2; ras = 1'b0; step();
    oe = 1'b1; addr = 3'd3; cas = 1'b0; step();
    chk("R3 oe high no drive", 32'(oe0), 0);
    oe = 1'b0; step();
    chk("R3 oe low drive", 32'(oe0), 1);
    chk("R3 oe low data", 32'(q0), 32'(pat(2, 3)));
    cas = 1'b1; step();
    ras = 1'b1; step();

    // R4 late write, OE high, data taken at WE fall
    addr = 3'd1; ras = 1'b0; step();
    oe = 1'b1; addr = 3'd4; dq = 8'h00; cas = 1'b0; step();
    dq = 8'h5A; we = 1'b0; step();
    cas = 1'b1; we = 1'b1; step();
    ras = 1'b1; oe = 1'b0; step();
    rd(1, 4, 8'h5A, "R4 late write");

    // R5 late write with OE low is dropped
    addr = 3'd6; ras = 1'b0; step();
    addr = 3'd6; cas = 1'b0; step();
    chk("R5 pre read", 32'(q0), 32'(pat(6, 6)));
    dq = 8'hC3; we = 1'b0; step();
    chk("R5 still drives u0", 32'(oe0), 1);
    chk("R5 old data u0", 32'(q0), 32'(pat(6, 6)));
    chk("R5 still drives u1", 32'(oe1), 1);
    cas = 1'b1; we = 1'b1; step();
    ras = 1'b1; step();
    rd(6, 6, pat(6, 6), "R5 not written");

    // R6 read-modify-write
    addr = 3'd3; ras = 1'b0; step();
    addr = 3'd1; cas = 1'b0; step();
    chk("R6 read phase", 32'(q0), 32'(pat(3, 1)));
    oe = 1'b1; step();
    chk("R6 oe off", 32'(oe0), 0);
    dq = 8'hA6; we = 1'b0; step();
    cas = 1'b1; we = 1'b1; oe = 1'b0; step();
    ras = 1'b1; step();
    rd(3, 1, 8'hA6, "R6 modified");

    // R9 counter refresh with wrap, R10 RAS-only in the middle
    for (int i = 0; i < 14; i++) begin
      if (i == 7) begin
        addr = 3'd5; ras = 1'b0; step();
        chk("R10 ras-only pulse", 32'(rf0), 1);
        chk("R10 ras-only row", 32'(rr0), 5);
        ras = 1'b1; step();
      end
      cbr();
    end

    // R11 WE-low CBR ordering
    we = 1'b0; step();
    chk("R11 idle we fall no err", 32'(er0), 0);
    cas = 1'b0; step();
    chk("R11 err u0", 32'(er0), 1);
    chk("R11 err u1", 32'(er1), 1);
    cas = 1'b1; step();
    chk("R11 err one cycle", 32'(er0), 0);
    we = 1'b1; step();

    // R12 WE edge during a refresh
    cas = 1'b0; step();
    ras = 1'b0; step();
    chk("R12 cbr row", 32'(rr0), 32'(ncbr % SPAN));
    ncbr++;
    we = 1'b0; step();
    chk("R12 err", 32'(er0), 1);
    we = 1'b1; step();
    cas = 1'b1; step();
    ras = 1'b1; step();
    chk("R12 err cleared", 32'(er0), 0);
    rd(0, 0, pat(0, 0), "R12 array intact");
    cbr();

    summary();
    $finish;
  end
endmodule